// File: doc/BRIEF.md
# Shift-Register Sequence Generator with Switching-Leakage Monitor

This block is a Fibonacci linear feedback shift register whose width and feedback taps are parameters. Alongside the register it models how the register leaks through dynamic power. Every time the register advances, the block reports how many of its bits toggled on that step. It also reports one bit that says whether that toggle count differs from the count of the step before. That bit stream is what an observer of supply current would collect and pass to a linear-complexity solver in order to rebuild the register. The solver is not part of this block.

Software or a test harness loads a seed, pulses the step enable, and reads the register contents, the toggle count and the change bit. A zero seed would lock the register, so the block replaces it with the value 1. Each of the two leakage outputs has a valid flag, because a toggle count needs one step after a load and a change bit needs two.

Top module: `lfsr_leak_mon`

## Requirements
- R1: After reset, `state` is 1 and `hd`, `hd_valid`, `chg` and `chg_valid` are all 0.
- R2: When `load` is high at a clock edge, `state` takes the value of `seed` at that edge. `load` takes priority over `en`.
- R3: A load with `seed` equal to zero places the value 1 in `state`.
- R4: When `en` is high and `load` is low at a clock edge, `state` shifts one place toward the MSB. Its new bit 0 is the XOR of the old state bits selected by the tap mask. With the default 4-bit width the mask is 4'b1001, which selects bits 3 and 0.
- R5: When `load` and `en` are both low at a clock edge, `state`, `hd`, `hd_valid`, `chg` and `chg_valid` keep their values.
- R6: After each step, `hd` equals the number of bit positions in which `state` differs from its value before that step, and `hd_valid` is 1.
- R7: On every step after the first step following a load, `chg` is 1 if that step's `hd` differs from the previous step's `hd`, and 0 if the two are equal. `chg_valid` is 1 on those steps.
- R8: A load clears `hd`, `hd_valid`, `chg` and `chg_valid` to 0. `hd_valid` stays 0 until the first step after the load. `chg_valid` stays 0 until the second step after the load.
- R9: With the default width and taps and a nonzero seed, `state` returns to the seed after exactly 15 steps, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load | input | 1 | Load `seed` into the register |
| seed | input | N | Seed value; zero is replaced by 1 |
| en | input | 1 | Advance the register by one step |
| state | output | N | Register contents |
| hd | output | clog2(N+1) | Number of bits that toggled on the last step |
| hd_valid | output | 1 | `hd` holds a real measurement |
| chg | output | 1 | Last toggle count differs from the one before it |
| chg_valid | output | 1 | `chg` holds a real comparison |

## Verification
A wrong feedback tap or a wrong shift direction appears on `state` at the first step. After that it breaks the 15-step period, so the sequence and the period checks catch it. If the stored previous count is wrong, `chg` is wrong as soon as the comparison becomes valid, which is two steps after a load. If the valid flags are not cleared on a load, `hd_valid` and `chg_valid` are seen high one cycle after the load edge. A hold that lets state slip shows on `state` in the very next cycle.

// File: rtl/lfsr_leak_pkg.sv
package lfsr_leak_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_STEP = 2'd2
  } lfsr_op_e;
endpackage

// File: rtl/lfsr_step.sv
module lfsr_step
  import lfsr_leak_pkg::*;
#(
  parameter int unsigned N    = 4,
  parameter logic [N-1:0] TAPS = 4'b1001
) (
  input  logic [N-1:0] cur,
  input  logic [N-1:0] seed,
  input  lfsr_op_e     op,
  output logic [N-1:0] nxt
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic         fb;
  logic [N-1:0] shifted;
  logic [N-1:0] seed_ok;

  assign fb = ^(cur & TAPS);

  generate
    if (N > 1) begin : g_wide
      assign shifted = {cur[N-2:0], fb};
    end else begin : g_single
      assign shifted = fb;
    end
  endgenerate

  assign seed_ok = (seed == '0) ? ONE : seed;

  always_comb begin
    case (op)
      OP_LOAD: nxt = seed_ok;
      OP_STEP: nxt = shifted;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/lfsr_popcount.sv
module lfsr_popcount #(
  parameter int unsigned N   = 4,
  parameter int unsigned CW  = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) begin
      count = count + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/lfsr_hd_track.sv
module lfsr_hd_track
  import lfsr_leak_pkg::*;
#(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lfsr_op_e      op,
  input  logic [CW-1:0] hd_new,
  output logic [CW-1:0] hd,
  output logic          hd_valid,
  output logic          chg,
  output logic          chg_valid
);
  logic [CW-1:0] hd_q, hd_d;
  logic          hv_q, hv_d;
  logic          chg_q, chg_d;
  logic          cv_q, cv_d;

  always_comb begin
    hd_d  = hd_q;
    hv_d  = hv_q;
    chg_d = chg_q;
    cv_d  = cv_q;
    case (op)
      OP_LOAD: begin
        hd_d  = '0;
        hv_d  = 1'b0;
        chg_d = 1'b0;
        cv_d  = 1'b0;
      end
      OP_STEP: begin
        hd_d = hd_new;
        hv_d = 1'b1;
        if (hv_q) begin
          chg_d = (hd_new != hd_q);
          cv_d  = 1'b1;
        end else begin
          chg_d = 1'b0;
          cv_d  = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q  <= '0;
      hv_q  <= 1'b0;
      chg_q <= 1'b0;
      cv_q  <= 1'b0;
    end else if (op != OP_HOLD) begin
      hd_q  <= hd_d;
      hv_q  <= hv_d;
      chg_q <= chg_d;
      cv_q  <= cv_d;
    end
  end

  assign hd        = hd_q;
  assign hd_valid  = hv_q;
  assign chg       = chg_q;
  assign chg_valid = cv_q;
endmodule

// File: rtl/lfsr_leak_mon.sv
module lfsr_leak_mon
  import lfsr_leak_pkg::*;
#(
  parameter int unsigned  N    = 4,
  parameter logic [N-1:0] TAPS = 4'b1001,
  localparam int unsigned CW   = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [N-1:0]  seed,
  input  logic          en,
  output logic [N-1:0]  state,
  output logic [CW-1:0] hd,
  output logic          hd_valid,
  output logic          chg,
  output logic          chg_valid
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic          rst_meta, rst_sync_n;
  lfsr_op_e      op;
  logic [N-1:0]  state_q, state_d;
  logic [CW-1:0] hd_new;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    if (load)    op = OP_LOAD;
    else if (en) op = OP_STEP;
    else         op = OP_HOLD;
  end

  lfsr_step #(.N(N), .TAPS(TAPS)) u_step (
    .cur  (state_q),
    .seed (seed),
    .op   (op),
    .nxt  (state_d)
  );

  lfsr_popcount #(.N(N), .CW(CW)) u_pop (
    .vec   (state_q ^ state_d),
    .count (hd_new)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ONE;
    end else if (op != OP_HOLD) begin
      state_q <= state_d;
    end
  end

  lfsr_hd_track #(.CW(CW)) u_track (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .op        (op),
    .hd_new    (hd_new),
    .hd        (hd),
    .hd_valid  (hd_valid),
    .chg       (chg),
    .chg_valid (chg_valid)
  );

  assign state = state_q;
endmodule

// File: rtl/lfsr_leak_mon_chk.sv
module lfsr_leak_mon_chk #(
  parameter int unsigned N  = 4,
  parameter int unsigned CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic [N-1:0]  seed,
  input logic          en,
  input logic [N-1:0]  state,
  input logic [CW-1:0] hd,
  input logic          hd_valid,
  input logic          chg,
  input logic          chg_valid
);
  logic step;
  assign step = en && !load;

  assert_load_seed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seed != '0) |=> state == $past(seed));

  assert_zero_seed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seed == '0) |=> state == N'(1));

  assert_never_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !en) |=> ($stable(state) && $stable(hd) && $stable(hd_valid)
                        && $stable(chg) && $stable(chg_valid)));

  assert_hd_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (hd_valid && hd == CW'($countones($past(state) ^ state))));

  assert_chg_cmp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && hd_valid) |=> (chg_valid && chg == ($past(hd) != hd)));

  assert_load_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!hd_valid && !chg_valid));

  assert_valid_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chg_valid |-> hd_valid);
endmodule

bind lfsr_leak_mon lfsr_leak_mon_chk #(.N(N), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .load      (load),
  .seed      (seed),
  .en        (en),
  .state     (state),
  .hd        (hd),
  .hd_valid  (hd_valid),
  .chg       (chg),
  .chg_valid (chg_valid)
);

// File: tb/lfsr_leak_mon_bench.sv
module lfsr_leak_mon_bench;
  localparam int N  = 4;
  localparam int CW = 3;

  logic          clk;
  logic          rst_n;
  logic          load;
  logic [N-1:0]  seed;
  logic          en;
  logic [N-1:0]  state;
  logic [CW-1:0] hd;
  logic          hd_valid;
  logic          chg;
  logic          chg_valid;

  int n_checks = 0;
  int n_fail   = 0;

  logic [N-1:0] m_s;
  int           m_h;
  logic         m_hv, m_c, m_cv;

  lfsr_leak_mon u_lfsr_leak_mon (
    .clk(clk), .rst_n(rst_n), .load(load), .seed(seed), .en(en),
    .state(state), .hd(hd), .hd_valid(hd_valid), .chg(chg), .chg_valid(chg_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model_next(logic [N-1:0] s);
    return {s[N-2:0], s[3] ^ s[0]};
  endfunction

  function automatic int ones(logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) c += v[i];
    return c;
  endfunction

  task automatic drive(logic l, logic [N-1:0] sd, logic e);
    logic [N-1:0] nx;
    int h;
    @(negedge clk);
    load = l; seed = sd; en = e;
    @(posedge clk);
    #1;
    if (l) begin
      m_s = (sd == '0) ? N'(1) : sd;
      m_h = 0; m_hv = 0; m_c = 0; m_cv = 0;
    end else if (e) begin
      nx = model_next(m_s);
      h  = ones(m_s ^ nx);
      if (m_hv) begin m_c = (h != m_h); m_cv = 1; end
      else      begin m_c = 0; m_cv = 0; end
      m_h = h; m_hv = 1; m_s = nx;
    end
  endtask

  task automatic compare_all(string req);
    check({req, " state"}, state, m_s);
    check({req, " hd"}, hd, m_h);
    check({req, " hd_valid"}, hd_valid, m_hv);
    check({req, " chg_valid"}, chg_valid, m_cv);
    if (m_cv) check({req, " chg"}, chg, m_c);
  endtask

  task automatic t_reset_R1();
    check("R1 state", state, 1);
    check("R1 hd", hd, 0);
    check("R1 hd_valid", hd_valid, 0);
    check("R1 chg", chg, 0);
    check("R1 chg_valid", chg_valid, 0);
    m_s = 1; m_h = 0; m_hv = 0; m_c = 0; m_cv = 0;
  endtask

  task automatic t_load_R2();
    drive(1, 4'b1000, 1);
    check("R2 load beats en", state, 4'b1000);
    check("R8 hd_valid after load", hd_valid, 0);
    drive(1, 4'b0101, 0);
    check("R2 plain load", state, 4'b0101);
  endtask

  task automatic t_zero_seed_R3();
    drive(1, 4'b0000, 0);
    check("R3 zero seed", state, 1);
  endtask

  task automatic t_sequence_R4_R6_R7();
    drive(1, 4'b0110, 0);
    compare_all("R8 after load");
    drive(0, 0, 1);
    compare_all("R6 first step");
    check("R8 chg_valid low after one step", chg_valid, 0);
    for (int i = 0; i < 20; i++) begin
      drive(0, 0, 1);
      compare_all("R4 R6 R7 run");
    end
  endtask

  task automatic t_hold_R5();
    logic [N-1:0] s0 = state;
    for (int i = 0; i < 3; i++) begin
      drive(0, 4'b1111, 0);
      check("R5 hold state", state, s0);
      compare_all("R5 hold outputs");
    end
    drive(0, 0, 1);
    compare_all("R7 step after hold");
  endtask

  task automatic t_reload_R8();
    drive(0, 0, 1);
    drive(1, 4'b1011, 1);
    check("R8 hd cleared", hd, 0);
    check("R8 hd_valid cleared", hd_valid, 0);
    check("R8 chg cleared", chg, 0);
    check("R8 chg_valid cleared", chg_valid, 0);
    drive(0, 0, 1);
    check("R8 hd_valid after step", hd_valid, 1);
    check("R8 chg_valid after one step", chg_valid, 0);
    drive(0, 0, 1);
    check("R8 chg_valid after two steps", chg_valid, 1);
    compare_all("R7 after reload");
  endtask

  task automatic t_period_R9();
    int first = 0;
    drive(1, 4'b0001, 0);
    for (int i = 1; i <= 16; i++) begin
      drive(0, 0, 1);
      if (first == 0 && state == 4'b0001) first = i;
    end
    check("R9 period", first, 15);
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load = 1'b0; seed = '0; en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_R1();
    t_load_R2();
    t_zero_seed_R3();
    t_sequence_R4_R6_R7();
    t_hold_R5();
    t_reload_R8();
    t_period_R9();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule